// File: doc/BRIEF.md
# Operand Addressing Mode Decoder

This block turns one operand field of a 16-bit instruction word into the location that the operand names. That location can be a general register, a memory address, the stack pointer, the program counter, the overflow register, or an immediate value. The caller presents the mode code and a flag that says whether it is the 6-bit source field (a) or the 5-bit destination field (b). It also presents the eight general registers, the stack pointer, the program counter and the word fetched at the program counter. One cycle later the block returns the location together with its bookkeeping:

- whether the operand consumed the word that follows the instruction, and its extra cycle cost;
- the updated program counter and stack pointer;
- whether a result may be written back to that location.

The block also has a skip helper. Given the instruction word that a failed conditional test must step over, it returns how many words to advance. The sequencer decodes field a before field b, so any stack or program-counter side effects of a must be applied before b is presented. Memory access and arithmetic happen outside this block.

Top module: `opd_decode_top`

## Requirements
- R1: While `rst` is high on a clock edge, `out_valid`, `loc_kind`, `loc_value`, `words_used`, `extra_cycle`, `pc_next`, `sp_next`, `dest_writable` and `skip_len` are all zero after that edge.
- R2: `out_valid` is high exactly one cycle after `in_valid` was high. The registered results belong to the inputs of that cycle. `nw_addr` always equals `pc_in`.
- R3: Codes 0x00–0x07 give kind REG (`loc_kind`=0), with `loc_value` equal to the register index (A=0, B=1, C=2, X=3, Y=4, Z=5, I=6, J=7). They use no extra word and are writable.
- R4: Codes 0x08–0x0F give kind MEM (`loc_kind`=1). The address is the value of register (code & 7). They use no extra word.
- R5: Codes 0x10–0x17 give kind MEM at the address register (code & 7) + `nw_data`, with `words_used`=1.
- R6: Code 0x18 on field a gives MEM at SP with `sp_next`=SP+1 (pop). On field b it gives MEM at SP−1 with `sp_next`=SP−1 (push). All other codes leave `sp_next`=SP.
- R7: Code 0x19 gives MEM at SP. Code 0x1A gives MEM at SP + `nw_data` with `words_used`=1.
- R8: Codes 0x1B, 0x1C and 0x1D give kinds SP (2), PC (3) and EX (4) respectively. They are writable and have `loc_value`=0.
- R9: Code 0x1E gives MEM at address `nw_data`. Code 0x1F gives IMM (`loc_kind`=5) with value `nw_data`. Both have `words_used`=1.
- R10: On field a, codes 0x20–0x3F give IMM with value (code − 0x21) mod 2^16, so 0x20 gives 0xFFFF and 0x3F gives 0x001E. They use no extra word.
- R11: `dest_writable` is 0 for every code of 0x1F or above and 1 for every code below it.
- R12: When `is_field_a`=0, bit 5 of `code` is ignored.
- R13: `pc_next` = `pc_in` + `words_used` and `extra_cycle` = `words_used`.
- R14: For the instruction in `skip_insn`, `skip_len` is 1 plus one for each of the 5-bit views of field a (bits 14:10) and field b (bits 9:5) that matches 1111x or 10xxx.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Decode request this cycle |
| is_field_a | input | 1 | 1: decode source field a (6-bit); 0: destination field b (5-bit) |
| code | input | 6 | Operand mode code |
| gpr_flat | input | 128 | Eight 16-bit general registers, register n at bits 16n+15:16n |
| sp_in | input | 16 | Current stack pointer |
| pc_in | input | 16 | Current program counter (points at the word after the operand's instruction word) |
| nw_addr | output | 16 | Address of the extra instruction word to fetch |
| nw_data | input | 16 | Word read at `nw_addr` |
| skip_insn | input | 16 | Instruction word to be skipped |
| out_valid | output | 1 | Registered result valid |
| loc_kind | output | 3 | 0 REG, 1 MEM, 2 SP, 3 PC, 4 EX, 5 IMM |
| loc_value | output | 16 | Register index, memory address or immediate value |
| words_used | output | 1 | Operand consumed the extra word |
| extra_cycle | output | 1 | Extra cycle cost of the operand |
| pc_next | output | 16 | Program counter after the operand |
| sp_next | output | 16 | Stack pointer after the operand |
| dest_writable | output | 1 | A write to this location takes effect |
| skip_len | output | 2 | Words to advance when skipping `skip_insn` |

## Verification
A wrong mode classification shows up on the cycle after the request: the location kind or the address is wrong, or the word and cycle counts disagree with the updated program counter. Stack errors show up at once as an `sp_next` that is not SP, SP+1 or SP−1 in the right direction. The table covers one code from every mode group on both fields. That includes the push/pop split, the literal endpoints and the ignored high bit on field b. A skip-count fault shows up as a wrong `skip_len` for instructions whose fields straddle the 1111x and 10xxx patterns, including a long literal whose low five bits happen to match.

// File: rtl/opd_pkg.sv
package opd_pkg;

    localparam int WORD_W = 16;
    localparam int CODE_W = 6;
    localparam int FIELD_B_W = 5;
    localparam int NUM_GPR = 8;
    localparam int IDX_W = $clog2(NUM_GPR);
    localparam logic [WORD_W-1:0] LIT_BIAS = 16'h0021;

    typedef enum logic [2:0] {
        LK_REG = 3'd0,
        LK_MEM = 3'd1,
        LK_SP  = 3'd2,
        LK_PC  = 3'd3,
        LK_EX  = 3'd4,
        LK_IMM = 3'd5
    } loc_kind_e;

    typedef enum logic [1:0] {
        BASE_ZERO   = 2'd0,
        BASE_GPR    = 2'd1,
        BASE_SP     = 2'd2,
        BASE_SP_DEC = 2'd3
    } base_sel_e;

    typedef enum logic [1:0] {
        SPA_HOLD = 2'd0,
        SPA_INC  = 2'd1,
        SPA_DEC  = 2'd2
    } sp_adj_e;

    typedef struct packed {
        loc_kind_e        kind;
        logic [IDX_W-1:0] idx;
        base_sel_e        base;
        logic             add_nw;
        logic             short_lit;
        sp_adj_e          sp_adj;
        logic             uses_nw;
        logic             writable;
    } mode_t;

    // A field that makes the skip sequence step over one more word
    function automatic logic field_takes_word(input logic [FIELD_B_W-1:0] f);
        return (f[4:1] == 4'b1111) || (f[4:3] == 2'b10);
    endfunction

endpackage

// File: rtl/opd_mode_classify.sv
module opd_mode_classify
    import opd_pkg::*;
#(
    parameter int CW = CODE_W
) (
    input  logic          is_a,
    input  logic [CW-1:0] code,
    output mode_t         mode
);
    logic [CW-1:0] view;

    always_comb begin
        view = is_a ? code : {1'b0, code[CW-2:0]};
        mode = '{kind: LK_REG, idx: '0, base: BASE_ZERO, add_nw: 1'b0,
                 short_lit: 1'b0, sp_adj: SPA_HOLD, uses_nw: 1'b0, writable: 1'b1};
        if (view[5]) begin
            mode.kind      = LK_IMM;
            mode.short_lit = 1'b1;
            mode.writable  = 1'b0;
        end else begin
            case (view[4:3])
                2'b00: begin
                    mode.kind = LK_REG;
                    mode.idx  = view[IDX_W-1:0];
                end
                2'b01: begin
                    mode.kind = LK_MEM;
                    mode.idx  = view[IDX_W-1:0];
                    mode.base = BASE_GPR;
                end
                2'b10: begin
                    mode.kind    = LK_MEM;
                    mode.idx     = view[IDX_W-1:0];
                    mode.base    = BASE_GPR;
                    mode.add_nw  = 1'b1;
                    mode.uses_nw = 1'b1;
                end
                default: begin
                    case (view[2:0])
                        3'd0: begin
                            mode.kind   = LK_MEM;
                            mode.base   = is_a ? BASE_SP : BASE_SP_DEC;
                            mode.sp_adj = is_a ? SPA_INC : SPA_DEC;
                        end
                        3'd1: begin
                            mode.kind = LK_MEM;
                            mode.base = BASE_SP;
                        end
                        3'd2: begin
                            mode.kind    = LK_MEM;
                            mode.base    = BASE_SP;
                            mode.add_nw  = 1'b1;
                            mode.uses_nw = 1'b1;
                        end
                        3'd3: mode.kind = LK_SP;
                        3'd4: mode.kind = LK_PC;
                        3'd5: mode.kind = LK_EX;
                        3'd6: begin
                            mode.kind    = LK_MEM;
                            mode.base    = BASE_ZERO;
                            mode.add_nw  = 1'b1;
                            mode.uses_nw = 1'b1;
                        end
                        default: begin
                            mode.kind     = LK_IMM;
                            mode.uses_nw  = 1'b1;
                            mode.writable = 1'b0;
                        end
                    endcase
                end
            endcase
        end
    end

endmodule

// File: rtl/opd_loc_build.sv
module opd_loc_build
    import opd_pkg::*;
#(
    parameter int W  = WORD_W,
    parameter int N  = NUM_GPR,
    parameter int CW = CODE_W
) (
    input  mode_t         mode,
    input  logic [CW-1:0] code,
    input  logic [N*W-1:0] gpr_flat,
    input  logic [W-1:0]  sp,
    input  logic [W-1:0]  pc,
    input  logic [W-1:0]  nw,
    output logic [W-1:0]  value,
    output logic [W-1:0]  pc_after,
    output logic [W-1:0]  sp_after
);
    logic [W-1:0] gpr [N];
    logic [W-1:0] base_val;
    logic [W-1:0] lit_val;

    for (genvar g = 0; g < N; g++) begin : g_unpack
        assign gpr[g] = gpr_flat[g*W +: W];
    end

    always_comb begin
        case (mode.base)
            BASE_GPR:    base_val = gpr[mode.idx];
            BASE_SP:     base_val = sp;
            BASE_SP_DEC: base_val = sp - W'(1);
            default:     base_val = '0;
        endcase
        lit_val = W'(code) - LIT_BIAS[W-1:0];
        case (mode.kind)
            LK_REG:  value = W'(mode.idx);
            LK_MEM:  value = base_val + (mode.add_nw ? nw : '0);
            LK_IMM:  value = mode.short_lit ? lit_val : nw;
            default: value = '0;
        endcase
        pc_after = pc + W'(mode.uses_nw);
        case (mode.sp_adj)
            SPA_INC: sp_after = sp + W'(1);
            SPA_DEC: sp_after = sp - W'(1);
            default: sp_after = sp;
        endcase
    end

endmodule

// File: rtl/opd_skip_len.sv
module opd_skip_len
    import opd_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  logic [W-1:0] insn,
    output logic [1:0]   len
);
    logic [FIELD_B_W-1:0] a_low;
    logic [FIELD_B_W-1:0] b_fld;

    always_comb begin
        a_low = insn[14:10];
        b_fld = insn[9:5];
        len   = 2'd1 + 2'(field_takes_word(a_low)) + 2'(field_takes_word(b_fld));
    end

endmodule

// File: rtl/opd_decode_top.sv
module opd_decode_top
    import opd_pkg::*;
#(
    parameter int W  = WORD_W,
    parameter int N  = NUM_GPR,
    parameter int CW = CODE_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           in_valid,
    input  logic           is_field_a,
    input  logic [CW-1:0]  code,
    input  logic [N*W-1:0] gpr_flat,
    input  logic [W-1:0]   sp_in,
    input  logic [W-1:0]   pc_in,
    output logic [W-1:0]   nw_addr,
    input  logic [W-1:0]   nw_data,
    input  logic [W-1:0]   skip_insn,
    output logic           out_valid,
    output logic [2:0]     loc_kind,
    output logic [W-1:0]   loc_value,
    output logic           words_used,
    output logic           extra_cycle,
    output logic [W-1:0]   pc_next,
    output logic [W-1:0]   sp_next,
    output logic           dest_writable,
    output logic [1:0]     skip_len
);
    mode_t        mode;
    logic [W-1:0] value_c;
    logic [W-1:0] pc_c;
    logic [W-1:0] sp_c;
    logic [1:0]   skip_c;

    assign nw_addr = pc_in;

    opd_mode_classify #(.CW(CW)) u_classify (
        .is_a (is_field_a),
        .code (code),
        .mode (mode)
    );

    opd_loc_build #(.W(W), .N(N), .CW(CW)) u_build (
        .mode     (mode),
        .code     (code),
        .gpr_flat (gpr_flat),
        .sp       (sp_in),
        .pc       (pc_in),
        .nw       (nw_data),
        .value    (value_c),
        .pc_after (pc_c),
        .sp_after (sp_c)
    );

    opd_skip_len #(.W(W)) u_skip (
        .insn (skip_insn),
        .len  (skip_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid     <= 1'b0;
            loc_kind      <= '0;
            loc_value     <= '0;
            words_used    <= 1'b0;
            extra_cycle   <= 1'b0;
            pc_next       <= '0;
            sp_next       <= '0;
            dest_writable <= 1'b0;
            skip_len      <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                loc_kind      <= mode.kind;
                loc_value     <= value_c;
                words_used    <= mode.uses_nw;
                extra_cycle   <= mode.add_nw | (mode.kind == LK_IMM && !mode.short_lit);
                pc_next       <= pc_c;
                sp_next       <= sp_c;
                dest_writable <= mode.writable;
                skip_len      <= skip_c;
            end
        end
    end

    // R2
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    // R2
    valid_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    // R13
    pc_step_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> pc_next == $past(pc_in) + W'(words_used));
    // R13
    cycle_match_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> extra_cycle == words_used);
    // R6
    sp_step_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (sp_next == $past(sp_in)) || (sp_next == $past(sp_in) + W'(1))
                     || (sp_next == $past(sp_in) - W'(1)));
    // R11
    lit_ro_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid && loc_kind == 3'(LK_IMM) |-> !dest_writable);
    // R3
    reg_no_word_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid && loc_kind == 3'(LK_REG) |-> !words_used && dest_writable);
    // R14
    skip_range_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> skip_len != 2'd0);

endmodule

// File: tb/opd_decode_top_test.sv
module opd_decode_top_test;

    logic         clk = 1'b0;
    logic         rst;
    logic         in_valid;
    logic         is_field_a;
    logic [5:0]   code;
    logic [127:0] gpr_flat;
    logic [15:0]  sp_in, pc_in, nw_data, skip_insn;
    logic [15:0]  nw_addr;
    logic         out_valid;
    logic [2:0]   loc_kind;
    logic [15:0]  loc_value;
    logic         words_used, extra_cycle, dest_writable;
    logic [15:0]  pc_next, sp_next;
    logic [1:0]   skip_len;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    opd_decode_top uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .is_field_a(is_field_a),
        .code(code), .gpr_flat(gpr_flat), .sp_in(sp_in), .pc_in(pc_in),
        .nw_addr(nw_addr), .nw_data(nw_data), .skip_insn(skip_insn),
        .out_valid(out_valid), .loc_kind(loc_kind), .loc_value(loc_value),
        .words_used(words_used), .extra_cycle(extra_cycle), .pc_next(pc_next),
        .sp_next(sp_next), .dest_writable(dest_writable), .skip_len(skip_len)
    );

    // Entry: [47:44] req, [43] field a, [42:37] code, [36:34] kind,
    // [33:18] value, [17] words, [16:1] sp_next, [0] writable
    // Fixed context: reg n = 0x1000 + 0x100*n, SP 0x8000, PC 0x0200, next word 0x0030
    localparam int NV = 18;
    localparam logic [47:0] VEC [NV] = '{
        {4'd3,  1'b1, 6'h00, 3'd0, 16'h0000, 1'b0, 16'h8000, 1'b1}, // R3
        {4'd3,  1'b0, 6'h07, 3'd0, 16'h0007, 1'b0, 16'h8000, 1'b1}, // R3
        {4'd4,  1'b1, 6'h0B, 3'd1, 16'h1300, 1'b0, 16'h8000, 1'b1}, // R4
        {4'd5,  1'b0, 6'h11, 3'd1, 16'h1130, 1'b1, 16'h8000, 1'b1}, // R5
        {4'd6,  1'b1, 6'h18, 3'd1, 16'h8000, 1'b0, 16'h8001, 1'b1}, // R6 pop
        {4'd6,  1'b0, 6'h18, 3'd1, 16'h7FFF, 1'b0, 16'h7FFF, 1'b1}, // R6 push
        {4'd7,  1'b1, 6'h19, 3'd1, 16'h8000, 1'b0, 16'h8000, 1'b1}, // R7 peek
        {4'd7,  1'b0, 6'h1A, 3'd1, 16'h8030, 1'b1, 16'h8000, 1'b1}, // R7 pick
        {4'd8,  1'b1, 6'h1B, 3'd2, 16'h0000, 1'b0, 16'h8000, 1'b1}, // R8
        {4'd8,  1'b0, 6'h1C, 3'd3, 16'h0000, 1'b0, 16'h8000, 1'b1}, // R8
        {4'd8,  1'b1, 6'h1D, 3'd4, 16'h0000, 1'b0, 16'h8000, 1'b1}, // R8
        {4'd9,  1'b0, 6'h1E, 3'd1, 16'h0030, 1'b1, 16'h8000, 1'b1}, // R9
        {4'd9,  1'b1, 6'h1F, 3'd5, 16'h0030, 1'b1, 16'h8000, 1'b0}, // R9 R11
        {4'd11, 1'b0, 6'h1F, 3'd5, 16'h0030, 1'b1, 16'h8000, 1'b0}, // R11
        {4'd10, 1'b1, 6'h20, 3'd5, 16'hFFFF, 1'b0, 16'h8000, 1'b0}, // R10
        {4'd10, 1'b1, 6'h21, 3'd5, 16'h0000, 1'b0, 16'h8000, 1'b0}, // R10
        {4'd10, 1'b1, 6'h3F, 3'd5, 16'h001E, 1'b0, 16'h8000, 1'b0}, // R10
        {4'd12, 1'b0, 6'h23, 3'd0, 16'h0003, 1'b0, 16'h8000, 1'b1}  // R12
    };

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic issue(input logic fa, input logic [5:0] c, input logic [15:0] insn);
        @(negedge clk);
        in_valid   = 1'b1;
        is_field_a = fa;
        code       = c;
        skip_insn  = insn;
        @(negedge clk);
        in_valid   = 1'b0;
    endtask

    function automatic logic [15:0] mk_insn(input logic [5:0] a, input logic [4:0] b);
        return {a, b, 5'h02};
    endfunction

    task automatic skip_case(input logic [5:0] a, input logic [4:0] b, input logic [1:0] exp);
        issue(1'b1, 6'h00, mk_insn(a, b));
        check(out_valid && skip_len == exp, "R14", {62'd0, skip_len}, {62'd0, exp});
    endtask

    initial begin
        #(4 * 100000);
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst = 1'b1; in_valid = 1'b0; is_field_a = 1'b1; code = '0;
        sp_in = 16'h8000; pc_in = 16'h0200; nw_data = 16'h0030; skip_insn = '0;
        for (int g = 0; g < 8; g++) gpr_flat[g*16 +: 16] = 16'h1000 + 16'(g) * 16'h0100;
        repeat (3) @(negedge clk);
        // R1
        check(!out_valid && loc_value == 0 && sp_next == 0 && pc_next == 0 &&
              skip_len == 0 && loc_kind == 0 && !dest_writable && !words_used,
              "R1", {loc_value, sp_next, pc_next, 16'(skip_len)}, 64'd0);
        rst = 1'b0;
        // R2
        check(nw_addr == pc_in, "R2", {48'd0, nw_addr}, {48'd0, pc_in});

        for (int v = 0; v < NV; v++) begin
            logic [47:0] e;
            logic [15:0] epc;
            e = VEC[v];
            issue(e[43], e[42:37], 16'h0000);
            epc = 16'h0200 + 16'(e[17]);
            check(out_valid && loc_kind == e[36:34] && loc_value == e[33:18] &&
                  words_used == e[17] && extra_cycle == e[17] && pc_next == epc &&
                  sp_next == e[16:1] && dest_writable == e[0],
                  $sformatf("R%0d vec%0d", e[47:44], v),
                  {7'd0, out_valid, 5'd0, loc_kind, loc_value, 3'd0, words_used,
                   3'd0, extra_cycle, sp_next, 7'd0, dest_writable},
                  {7'd0, 1'b1, 5'd0, e[36:34], e[33:18], 3'd0, e[17],
                   3'd0, e[17], e[16:1], 7'd0, e[0]});
        end

        // R2: result drops one cycle after the request ends
        @(negedge clk);
        check(!out_valid, "R2", {63'd0, out_valid}, 64'd0);

        // R13: pc_next tracks a different PC
        pc_in = 16'hFFFF;
        issue(1'b0, 6'h10, 16'h0000);
        check(pc_next == 16'h0000 && loc_value == 16'h1030, "R13",
              {32'd0, pc_next, loc_value}, {32'd0, 16'h0000, 16'h1030});
        check(nw_addr == 16'hFFFF, "R2", {48'd0, nw_addr}, 64'hFFFF);
        pc_in = 16'h0200;

        // R6: push wraps at SP 0
        sp_in = 16'h0000;
        issue(1'b0, 6'h18, 16'h0000);
        check(loc_value == 16'hFFFF && sp_next == 16'hFFFF, "R6",
              {32'd0, loc_value, sp_next}, {32'd0, 16'hFFFF, 16'hFFFF});
        sp_in = 16'h8000;

        // R14 skip lengths
        skip_case(6'h21, 5'h00, 2'd1);
        skip_case(6'h1E, 5'h10, 2'd3);
        skip_case(6'h3E, 5'h01, 2'd2);
        skip_case(6'h1F, 5'h17, 2'd3);
        skip_case(6'h1D, 5'h1E, 2'd2);

        // R1: reset clears a populated result
        issue(1'b1, 6'h3F, 16'h0000);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check(!out_valid && loc_value == 0 && loc_kind == 0 && skip_len == 0, "R1",
              {16'd0, 16'(loc_kind), loc_value, 16'(skip_len)}, 64'd0);
        rst = 1'b0;

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule